// File: doc/BRIEF.md
# Refresh Scheduler for a Synchronous DRAM Controller

This block lives inside a synchronous DRAM controller and keeps the array refreshed without help from software. An interval timer wraps every `REF_INTERVAL` clock cycles and adds one refresh to an owed count. While anything is owed and the block is idle, it raises a request towards the main command scheduler. The main scheduler grants that request once its own read and write traffic has drained, and from then on the refresh scheduler owns the command bus.

On a grant, the block first closes every open row with a precharge-all command if the scheduler reports that any bank is open. It then waits the row precharge time and issues one AUTO REFRESH. It drives NOP on the bus for the rest of the refresh cycle time, then returns to idle. The DRAM generates the row and bank to refresh internally, so only the A10 bit of the address bus is driven.

The owed count lets a refresh that was held back by a long burst still be served later. When two or more refreshes are owed, an urgent flag tells the main scheduler to stop delaying the grant. The precharge and refresh wait times are given in nanoseconds and are rounded up to whole clock cycles.

Top module: `refresh_sched`

## Requirements
- R1: Starting from reset, one refresh becomes owed every `REF_INTERVAL` cycles. The first is owed after exactly `REF_INTERVAL` rising edges, and the timer keeps running whether or not refreshes are served.
- R2: `ref_req_o` is high exactly when the block is idle and at least one refresh is owed.
- R3: `urgent_o` is high exactly when two or more refreshes are owed.
- R4: The owed count saturates at `MAX_DEBT`. Further timer wraps while it is saturated are dropped.
- R5: A grant taken while idle with `banks_open_i` high produces one cycle of precharge-all in the next cycle. Precharge-all is CS#=0, RAS#=0, CAS#=1, WE#=0, A10=1. NOP follows, and the AUTO REFRESH comes exactly RP cycles after the precharge, where RP = ceil(`T_RP_NS`/`CLK_NS`).
- R6: A grant taken while idle with `banks_open_i` low produces AUTO REFRESH in the next cycle. AUTO REFRESH is CS#=0, RAS#=0, CAS#=0, WE#=1; A10 is driven 0 and has no meaning.
- R7: After an AUTO REFRESH, the bus carries NOP (CS#=0, RAS#=1, CAS#=1, WE#=1, A10=0) for RC-1 cycles, with RC = ceil(`T_RC_NS`/`CLK_NS`). `busy_o` is high from the first command of a sequence until idle is reached, RC cycles after the refresh.
- R8: Each AUTO REFRESH removes one owed refresh. If a timer wrap falls in the same cycle, the owed count is unchanged.
- R9: A grant while nothing is owed has no effect: the bus stays NOP and `busy_o` stays low.
- R10: During reset the bus carries NOP, and `ref_req_o`, `urgent_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| banks_open_i | input | 1 | High when any bank still has a row open |
| ref_gnt_i | input | 1 | Grant from the main scheduler, sampled while idle |
| ref_req_o | output | 1 | Refresh owed and block idle |
| urgent_o | output | 1 | Two or more refreshes owed |
| busy_o | output | 1 | Block owns the command bus |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| a10_o | output | 1 | Address bit 10, the all-banks flag of precharge |

## Verification
Some properties are checked on every cycle:
- only the three legal command encodings ever appear on the bus;
- the refresh is followed by a command-free window of RC-1 cycles;
- the AUTO REFRESH lands exactly RP cycles after a precharge-all;
- a request never coexists with busy;
- an idle block with nothing owed never becomes busy.

Other behaviour can only be shown by the bench's scenarios, which compare the outputs every cycle against a timeline model. That covers the exact cycle at which refreshes become owed, saturation of the owed count, a timer wrap coinciding with a refresh, and the choice between precharging and refreshing directly as `banks_open_i` changes.

// File: rtl/refresh_pkg.sv
// Shared types for the refresh scheduler: command bus word, its three
// legal values, and the sequencer state encoding.
package refresh_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } dram_cmd_t;

    localparam dram_cmd_t CMD_NOP    = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    localparam dram_cmd_t CMD_PREALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
    localparam dram_cmd_t CMD_AREF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PRE,
        SQ_WAIT_RP,
        SQ_AREF,
        SQ_WAIT_RC
    } seq_state_t;

endpackage

// File: rtl/refresh_interval_tmr.sv
// Free-running interval timer. Emits a one-cycle tick every INTERVAL
// cycles; the first tick is in the cycle after INTERVAL-1 edges past reset.
// Assumes INTERVAL >= 2.
module refresh_interval_tmr #(
    parameter int INTERVAL = 1500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int TW = $clog2(INTERVAL + 1);
    localparam logic [TW-1:0] RELOAD = TW'(INTERVAL - 1);

    logic [TW-1:0] remain_q;

    assign tick_o = (remain_q == '0);

    // Count down to zero, then wrap to the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)      remain_q <= RELOAD;
        else if (tick_o) remain_q <= RELOAD;
        else             remain_q <= remain_q - 1'b1;
    end
endmodule

// File: rtl/refresh_debt.sv
// Owed-refresh counter. Adds one per timer tick, removes one per issued
// AUTO REFRESH, saturates at MAX_DEBT. Assumes MAX_DEBT >= 2.
module refresh_debt #(
    parameter int MAX_DEBT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic issue_i,
    output logic owed_o,
    output logic urgent_o
);
    localparam int DW = $clog2(MAX_DEBT + 1);
    localparam logic [DW-1:0] DMAX = DW'(MAX_DEBT);
    localparam logic [DW-1:0] TWO  = DW'(2);

    logic [DW-1:0] debt_q;

    // Net change of the owed count from tick and issue.
    always_ff @(posedge clk) begin
        if (!rst_n)
            debt_q <= '0;
        else if (tick_i && !issue_i && debt_q != DMAX)
            debt_q <= debt_q + 1'b1;
        else if (!tick_i && issue_i && debt_q != '0)
            debt_q <= debt_q - 1'b1;
    end

    assign owed_o   = (debt_q != '0);
    assign urgent_o = (debt_q >= TWO);
endmodule

// File: rtl/refresh_seq.sv
// Command sequencer. On a grant while idle and owed, closes open rows with
// precharge-all, waits RP_CYC, issues AUTO REFRESH, then holds NOP until
// RC_CYC cycles after the refresh. Assumes RP_CYC >= 1 and RC_CYC >= 1.
module refresh_seq
    import refresh_pkg::*;
#(
    parameter int RP_CYC = 2,
    parameter int RC_CYC = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      owed_i,
    input  logic      gnt_i,
    input  logic      banks_open_i,
    output dram_cmd_t cmd_o,
    output logic      issue_o,
    output logic      busy_o,
    output logic      req_o
);
    localparam int MAXC = (RC_CYC > RP_CYC) ? RC_CYC : RP_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t    state_q;
    logic [CW-1:0] wait_q;

    // Advance through precharge, refresh and the two wait windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            wait_q  <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (owed_i && gnt_i)
                        state_q <= banks_open_i ? SQ_PRE : SQ_AREF;
                end
                SQ_PRE: begin
                    if (RP_CYC > 1) begin
                        state_q <= SQ_WAIT_RP;
                        wait_q  <= CW'(RP_CYC - 2);
                    end else begin
                        state_q <= SQ_AREF;
                    end
                end
                SQ_WAIT_RP: begin
                    if (wait_q == '0) state_q <= SQ_AREF;
                    else              wait_q  <= wait_q - 1'b1;
                end
                SQ_AREF: begin
                    if (RC_CYC > 1) begin
                        state_q <= SQ_WAIT_RC;
                        wait_q  <= CW'(RC_CYC - 2);
                    end else begin
                        state_q <= SQ_IDLE;
                    end
                end
                SQ_WAIT_RC: begin
                    if (wait_q == '0) state_q <= SQ_IDLE;
                    else              wait_q  <= wait_q - 1'b1;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Decode the bus word from the current state.
    always_comb begin
        unique case (state_q)
            SQ_PRE:  cmd_o = CMD_PREALL;
            SQ_AREF: cmd_o = CMD_AREF;
            default: cmd_o = CMD_NOP;
        endcase
    end

    assign issue_o = (state_q == SQ_AREF);
    assign busy_o  = (state_q != SQ_IDLE);
    assign req_o   = (state_q == SQ_IDLE) && owed_i;
endmodule

// File: rtl/refresh_sched.sv
// Top of the refresh scheduler: interval timer, owed counter and command
// sequencer. Wait times are given in ns and rounded up to clock cycles.
module refresh_sched
    import refresh_pkg::*;
#(
    parameter int CLK_NS       = 10,
    parameter int T_RP_NS      = 18,
    parameter int T_RC_NS      = 60,
    parameter int REF_INTERVAL = 1500,
    parameter int MAX_DEBT     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic banks_open_i,
    input  logic ref_gnt_i,
    output logic ref_req_o,
    output logic urgent_o,
    output logic busy_o,
    output logic cs_n_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o,
    output logic a10_o
);
    localparam int RP_RAW = (T_RP_NS + CLK_NS - 1) / CLK_NS;
    localparam int RC_RAW = (T_RC_NS + CLK_NS - 1) / CLK_NS;
    localparam int RP_CYC = (RP_RAW < 1) ? 1 : RP_RAW;
    localparam int RC_CYC = (RC_RAW < 1) ? 1 : RC_RAW;

    logic      tick;
    logic      issue;
    logic      owed;
    dram_cmd_t cmd;

    refresh_interval_tmr #(.INTERVAL(REF_INTERVAL)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    refresh_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .issue_i  (issue),
        .owed_o   (owed),
        .urgent_o (urgent_o)
    );

    refresh_seq #(.RP_CYC(RP_CYC), .RC_CYC(RC_CYC)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .owed_i       (owed),
        .gnt_i        (ref_gnt_i),
        .banks_open_i (banks_open_i),
        .cmd_o        (cmd),
        .issue_o      (issue),
        .busy_o       (busy_o),
        .req_o        (ref_req_o)
    );

    assign cs_n_o  = cmd.cs_n;
    assign ras_n_o = cmd.ras_n;
    assign cas_n_o = cmd.cas_n;
    assign we_n_o  = cmd.we_n;
    assign a10_o   = cmd.a10;
endmodule

// File: rtl/refresh_sched_chk.sv
// Protocol checker for refresh_sched, observing its ports only.
module refresh_sched_chk #(
    parameter int CLK_NS  = 10,
    parameter int T_RP_NS = 18,
    parameter int T_RC_NS = 60
) (
    input logic clk,
    input logic rst_n,
    input logic ref_req_o,
    input logic urgent_o,
    input logic busy_o,
    input logic cs_n_o,
    input logic ras_n_o,
    input logic cas_n_o,
    input logic we_n_o,
    input logic a10_o
);
    localparam int RP_RAW = (T_RP_NS + CLK_NS - 1) / CLK_NS;
    localparam int RC_RAW = (T_RC_NS + CLK_NS - 1) / CLK_NS;
    localparam int RP_CYC = (RP_RAW < 1) ? 1 : RP_RAW;
    localparam int RC_CYC = (RC_RAW < 1) ? 1 : RC_RAW;

    logic [4:0] bus;
    logic       is_nop, is_pre, is_ref;
    int         rp_left, rc_left;

    assign bus    = {cs_n_o, ras_n_o, cas_n_o, we_n_o, a10_o};
    assign is_nop = (bus == 5'b01110);
    assign is_pre = (bus == 5'b00101);
    assign is_ref = (bus == 5'b00010);

    // Cycles until the refresh due after a precharge-all.
    always_ff @(posedge clk) begin
        if (!rst_n)         rp_left <= 0;
        else if (is_pre)    rp_left <= RP_CYC;
        else if (rp_left>0) rp_left <= rp_left - 1;
    end

    // Cycles left in the command-free window after a refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)         rc_left <= 0;
        else if (is_ref)    rc_left <= RC_CYC - 1;
        else if (rc_left>0) rc_left <= rc_left - 1;
    end

    // R5 R6 R7
    legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({is_nop, is_pre, is_ref}) == 1);

    // R5
    pre_to_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_left == 1) |-> is_ref);

    // R5
    pre_wait_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_left > 1) |-> is_nop);

    // R7
    blackout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_left != 0) |-> (is_nop && busy_o));

    // R2
    req_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |-> !busy_o);

    // R3
    urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (urgent_o && !busy_o) |-> ref_req_o);

    // R9
    no_owed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !ref_req_o) |=> !busy_o);

    // R7
    busy_has_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (is_pre || is_ref));
endmodule

bind refresh_sched refresh_sched_chk #(
    .CLK_NS (CLK_NS),
    .T_RP_NS(T_RP_NS),
    .T_RC_NS(T_RC_NS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_req_o(ref_req_o),
    .urgent_o (urgent_o),
    .busy_o   (busy_o),
    .cs_n_o   (cs_n_o),
    .ras_n_o  (ras_n_o),
    .cas_n_o  (cas_n_o),
    .we_n_o   (we_n_o),
    .a10_o    (a10_o)
);

// File: tb/test_refresh_sched.sv
// Self-checking bench: a timeline model of owed refreshes and bus phases,
// compared with the outputs on every falling edge.
module test_refresh_sched;
    localparam int CLK_NS = 10;
    localparam int TRP    = 18;
    localparam int TRC    = 60;
    localparam int IVL    = 40;
    localparam int MAXD   = 4;
    localparam int RP     = (TRP + CLK_NS - 1) / CLK_NS;
    localparam int RC     = (TRC + CLK_NS - 1) / CLK_NS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic banks_open = 1'b0;
    logic gnt = 1'b0;
    logic req, urg, busy, cs_n, ras_n, cas_n, we_n, a10;

    int n_chk = 0, n_err = 0, cyc = 0, first_req = -1;
    int obs_refs = 0, mdl_refs = 0;
    bit done = 1'b0, cmp_on = 1'b0;

    // Model state: phase 0 idle, 1 precharge, 2 wait RP, 3 refresh, 4 wait RC.
    int m_tmr, m_debt, m_ph, m_w;

    always #(CLK_NS/2) clk = ~clk;

    refresh_sched #(
        .CLK_NS(CLK_NS), .T_RP_NS(TRP), .T_RC_NS(TRC),
        .REF_INTERVAL(IVL), .MAX_DEBT(MAXD)
    ) i_refresh_sched (
        .clk(clk), .rst_n(rst_n), .banks_open_i(banks_open), .ref_gnt_i(gnt),
        .ref_req_o(req), .urgent_o(urg), .busy_o(busy),
        .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .a10_o(a10)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    // Timeline model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tmr = IVL - 1; m_debt = 0; m_ph = 0; m_w = 0;
        end else begin
            bit tick, iss;
            int owed_before;
            cyc++;
            tick = (m_tmr == 0);
            m_tmr = tick ? IVL - 1 : m_tmr - 1;
            iss = (m_ph == 3);
            owed_before = m_debt;
            if (tick && !iss && m_debt < MAXD) m_debt++;
            else if (!tick && iss && m_debt > 0) m_debt--;
            case (m_ph)
                0: if (owed_before > 0 && gnt) m_ph = banks_open ? 1 : 3;
                1: if (RP > 1) begin m_ph = 2; m_w = RP - 2; end else m_ph = 3;
                2: if (m_w == 0) m_ph = 3; else m_w--;
                3: if (RC > 1) begin m_ph = 4; m_w = RC - 2; end else m_ph = 0;
                default: if (m_w == 0) m_ph = 0; else m_w--;
            endcase
            if (m_ph == 3) mdl_refs++;
        end
    end

    // Compare every output against the model away from the clock edge.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            int exp_bus;
            string tag;
            case (m_ph)
                1:       begin exp_bus = 5'b00101; tag = "R5 precharge-all"; end
                2:       begin exp_bus = 5'b01110; tag = "R5 RP wait";       end
                3:       begin exp_bus = 5'b00010; tag = "R6 auto refresh";  end
                4:       begin exp_bus = 5'b01110; tag = "R7 RC blackout";   end
                default: begin exp_bus = 5'b01110; tag = "R9 idle NOP";      end
            endcase
            chk(tag, int'({cs_n, ras_n, cas_n, we_n, a10}), exp_bus);
            chk("R2/R8 request", int'(req), int'(m_ph == 0 && m_debt > 0));
            chk("R3 urgent", int'(urg), int'(m_debt >= 2));
            chk("R7 busy", int'(busy), int'(m_ph != 0));
            if (req && first_req < 0) first_req = cyc;
            if ({cs_n, ras_n, cas_n, we_n} == 4'b0001) obs_refs++;
        end
    end

    task automatic run(int n, bit g, bit bo);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            gnt = g;
            banks_open = bo;
        end
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 reset bus", int'({cs_n, ras_n, cas_n, we_n, a10}), 5'b01110);
        chk("R10 reset req", int'(req), 0);
        chk("R10 reset busy", int'(busy), 0);
        chk("R10 reset urgent", int'(urg), 0);
        // Grant before anything is owed must not start a sequence (R9).
        gnt = 1'b1;
        rst_n = 1'b1;
        cmp_on = 1'b1;
        run(IVL - 5, 1'b1, 1'b1);
        chk("R9 grant with nothing owed", int'(busy), 0);
        // Let three refreshes become owed.
        run(3 * IVL, 1'b0, 1'b0);
        chk("R1 first request cycle", first_req, IVL);
        chk("R3 urgent after backlog", int'(urg), 1);
        // Drain with banks open, toggling the open flag.
        for (int i = 0; i < 60; i++) run(1, 1'b1, (i % 7) < 4);
        // Long starvation to saturate the owed count.
        run(7 * IVL, 1'b0, 1'b0);
        begin
            int o0, m0;
            o0 = obs_refs;
            m0 = mdl_refs;
            run(35, 1'b1, 1'b0);
            chk("R4 refreshes served after saturation", obs_refs - o0, mdl_refs - m0);
            chk("R4 saturated drain count", int'((obs_refs - o0) <= MAXD + 1), 1);
        end
        // Sparse single-cycle grants with a mixed open-bank pattern (R8).
        for (int i = 0; i < 320; i++) run(1, (i % 5) == 0, (i % 3) == 0);
        run(20, 1'b0, 1'b0);
        chk("R8 total refreshes", obs_refs, mdl_refs);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_NS * 20000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule